// File: doc/BRIEF.md
# Three-Operand Raster Combine Stage

This block is the per-pixel combining stage of a 2D blitter. Each input beat carries a 32-bit word of four 8-bit pixels, a source word, a destination word and the screen position of the beat's first pixel. The block builds a pattern operand from an 8x8 monochrome tile. It optionally expands a 1-bit-per-pixel source into colour pixels. It then merges pattern, source and destination bit by bit through an 8-bit raster code, which covers all 256 three-input boolean functions.

Transparency never changes the data. It clears the byte enable of a pixel whose pattern bit or mono source bit is 0, so that pixel's destination byte is left unwritten. A single register stage with a ready/valid handshake on both sides holds the result. Its controller has two named states. `ST_EMPTY` means no result is held, and it moves to `ST_FULL` when a beat is accepted. `ST_FULL` means a result is held. It stays in `ST_FULL` when the result is stalled, or when it is consumed and a new beat is accepted in the same cycle. It returns to `ST_EMPTY` when the result is consumed and no new beat arrives.

Top module: `rop3_stage`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For every bit b of lane i, the result bit equals `cfg_rop[{P,S,D}]`. P is the pattern pixel bit, S the source pixel bit and D the destination bit, with P as the most significant index bit. Lane i occupies bits [8i+7:8i].
- R3: The pattern bit of lane i is `cfg_pat_tile[(in_y mod 8)*8 + ((in_x + i) mod 8)]`. The x position wraps within the tile, including across the lanes of one word.
- R4: The pattern pixel is `cfg_pat_fg` where the pattern bit is 1 and `cfg_pat_bg` where it is 0.
- R5: With `cfg_src_mono` = 1, lane i's source pixel is `cfg_src_fg` if `in_src[i]` is 1 and `cfg_src_bg` otherwise. With `cfg_src_mono` = 0, it is byte i of `in_src`.
- R6: With `cfg_src_transp` = 1 and `cfg_src_mono` = 1, lanes whose `in_src[i]` is 0 have `out_be[i]` = 0. With `cfg_src_mono` = 0, `cfg_src_transp` has no effect. Data is never altered by transparency.
- R7: With `cfg_pat_transp` = 1, lanes whose pattern bit is 0 have `out_be[i]` = 0. All other lanes have `out_be[i]` = 1 unless R6 clears them.
- R8: A beat accepted at a clock edge (`in_valid` and `in_ready`) is presented with `out_valid` = 1 right after that edge. Configuration is sampled at acceptance.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output stays unchanged and `in_ready` is 0. Otherwise `in_ready` is 1. Results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rop | input | 8 | Raster code, truth table indexed by {P,S,D} |
| cfg_src_mono | input | 1 | Treat source as 1 bit per pixel and expand it |
| cfg_src_transp | input | 1 | Source transparency enable |
| cfg_pat_transp | input | 1 | Pattern transparency enable |
| cfg_pat_tile | input | 64 | 8x8 mono pattern, row-major, row = y mod 8 |
| cfg_pat_fg | input | 8 | Pattern colour for bit 1 |
| cfg_pat_bg | input | 8 | Pattern colour for bit 0 |
| cfg_src_fg | input | 8 | Expanded source colour for bit 1 |
| cfg_src_bg | input | 8 | Expanded source colour for bit 0 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_x | input | 16 | X position of lane 0 |
| in_y | input | 16 | Y position of the beat |
| in_src | input | 32 | Source word (mono bits in [3:0]) |
| in_dst | input | 32 | Destination word |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Combined pixels |
| out_be | output | 4 | Per-pixel byte enables |

## Verification
On every cycle the assertions check the handshake. An accepted beat must appear at the output on the next edge. A stalled result must stay frozen, and an empty stage must be ready. They also check that fully transparent beats, whether every pattern bit or every mono source bit is 0, leave with all enables cleared. Only the bench scenarios can show the raster codes themselves, the tile indexing and the x wrap across lanes, the two colour expansions, and ordering under random backpressure. For these it compares each result word against a model computed from the requirements.

// File: rtl/rop_pkg.sv
package rop_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_t;
endpackage

// File: rtl/rop_pat_gen.sv
module rop_pat_gen #(
    parameter int LANES = 4,
    parameter int POS_W = 16,
    parameter int TILE  = 8
) (
    input  logic [POS_W-1:0]     pos_x,
    input  logic [POS_W-1:0]     pos_y,
    input  logic [TILE*TILE-1:0] tile,
    output logic [LANES-1:0]     pat_bits
);
    localparam int TLG = $clog2(TILE);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [POS_W-1:0] lane_x;
        logic [2*TLG-1:0] idx;
        assign lane_x      = pos_x + POS_W'(i);
        assign idx         = {pos_y[TLG-1:0], lane_x[TLG-1:0]};
        assign pat_bits[i] = tile[idx];
    end
endmodule

// File: rtl/rop_src_expand.sv
module rop_src_expand #(
    parameter int LANES = 4,
    parameter int PIX_W = 8
) (
    input  logic                   mono_en,
    input  logic [LANES*PIX_W-1:0] src_word,
    input  logic [PIX_W-1:0]       fg,
    input  logic [PIX_W-1:0]       bg,
    output logic [LANES*PIX_W-1:0] src_pix,
    output logic [LANES-1:0]       src_bits
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign src_bits[i] = src_word[i];
        assign src_pix[i*PIX_W +: PIX_W] = !mono_en ? src_word[i*PIX_W +: PIX_W]
                                         : (src_word[i] ? fg : bg);
    end
endmodule

// File: rtl/rop_lane.sv
module rop_lane #(
    parameter int PIX_W = 8
) (
    input  logic [7:0]       rop,
    input  logic [PIX_W-1:0] pat,
    input  logic [PIX_W-1:0] src,
    input  logic [PIX_W-1:0] dst,
    output logic [PIX_W-1:0] res
);
    for (genvar b = 0; b < PIX_W; b++) begin : g_bit
        assign res[b] = rop[{pat[b], src[b], dst[b]}];
    end
endmodule

// File: rtl/rop3_stage.sv
module rop3_stage
    import rop_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int POS_W = 16,
    parameter int TILE  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             cfg_rop,
    input  logic                   cfg_src_mono,
    input  logic                   cfg_src_transp,
    input  logic                   cfg_pat_transp,
    input  logic [TILE*TILE-1:0]   cfg_pat_tile,
    input  logic [PIX_W-1:0]       cfg_pat_fg,
    input  logic [PIX_W-1:0]       cfg_pat_bg,
    input  logic [PIX_W-1:0]       cfg_src_fg,
    input  logic [PIX_W-1:0]       cfg_src_bg,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [POS_W-1:0]       in_x,
    input  logic [POS_W-1:0]       in_y,
    input  logic [LANES*PIX_W-1:0] in_src,
    input  logic [LANES*PIX_W-1:0] in_dst,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*PIX_W-1:0] out_data,
    output logic [LANES-1:0]       out_be
);
    localparam int WORD_W = LANES * PIX_W;

    stage_st_t state_q, state_d;
    logic                accept;
    logic [LANES-1:0]    pat_bits;
    logic [LANES-1:0]    src_bits;
    logic [WORD_W-1:0]   src_pix;
    logic [WORD_W-1:0]   res_word;
    logic [LANES-1:0]    be_word;
    logic [WORD_W-1:0]   data_q;
    logic [LANES-1:0]    be_q;

    rop_pat_gen #(.LANES(LANES), .POS_W(POS_W), .TILE(TILE)) pat_i (
        .pos_x    (in_x),
        .pos_y    (in_y),
        .tile     (cfg_pat_tile),
        .pat_bits (pat_bits)
    );

    rop_src_expand #(.LANES(LANES), .PIX_W(PIX_W)) src_i (
        .mono_en  (cfg_src_mono),
        .src_word (in_src),
        .fg       (cfg_src_fg),
        .bg       (cfg_src_bg),
        .src_pix  (src_pix),
        .src_bits (src_bits)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PIX_W-1:0] pat_pix;
        assign pat_pix = pat_bits[i] ? cfg_pat_fg : cfg_pat_bg;

        rop_lane #(.PIX_W(PIX_W)) lane_i (
            .rop (cfg_rop),
            .pat (pat_pix),
            .src (src_pix[i*PIX_W +: PIX_W]),
            .dst (in_dst[i*PIX_W +: PIX_W]),
            .res (res_word[i*PIX_W +: PIX_W])
        );

        assign be_word[i] = !(cfg_pat_transp && !pat_bits[i])
                         && !(cfg_src_transp && cfg_src_mono && !src_bits[i]);
    end

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)                state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid)  state_d = ST_EMPTY;
            default:                               state_d = ST_EMPTY;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            be_q   <= '0;
        end else if (accept) begin
            data_q <= res_word;
            be_q   <= be_word;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_data  = data_q;
    assign out_be    = be_q;

    // R8
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be));

    // R9
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R7
    pat_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_pat_transp && (pat_bits == '0) |=> out_be == '0);

    // R6
    src_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_src_transp && cfg_src_mono && (src_bits == '0)
        |=> out_be == '0);
endmodule

// File: tb/rop3_stage_tb.sv
module rop3_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_rop = 8'hCC;
    logic        cfg_src_mono = 1'b0, cfg_src_transp = 1'b0, cfg_pat_transp = 1'b0;
    logic [63:0] cfg_pat_tile = '0;
    logic [7:0]  cfg_pat_fg = '0, cfg_pat_bg = '0, cfg_src_fg = '0, cfg_src_bg = '0;
    logic        in_valid = 1'b0, out_ready = 1'b1;
    logic [15:0] in_x = '0, in_y = '0;
    logic [31:0] in_src = '0, in_dst = '0;
    logic        in_ready, out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    int n_checks = 0, n_fail = 0;
    bit rnd_ready = 0;
    string phase = "R2";

    logic [35:0] exp_q [64];
    string       tag_q [64];
    int head = 0, tail = 0;

    always #5 clk = ~clk;

    rop3_stage dut_i (.*);

    function automatic logic [35:0] ref_calc(input logic [15:0] x, input logic [15:0] y,
                                             input logic [31:0] src, input logic [31:0] dst);
        logic [31:0] d;
        logic [3:0]  be;
        for (int i = 0; i < 4; i++) begin
            int idx;
            logic pb, sb;
            logic [7:0] pp, sp, dp;
            idx = int'(y[2:0]) * 8 + int'((x + 16'(i)) & 16'd7);
            pb = cfg_pat_tile[idx];
            pp = pb ? cfg_pat_fg : cfg_pat_bg;
            sb = src[i];
            sp = cfg_src_mono ? (sb ? cfg_src_fg : cfg_src_bg) : src[8*i +: 8];
            dp = dst[8*i +: 8];
            for (int b = 0; b < 8; b++) d[8*i+b] = cfg_rop[{pp[b], sp[b], dp[b]}];
            be[i] = !(cfg_pat_transp && !pb) && !(cfg_src_transp && cfg_src_mono && !sb);
        end
        return {be, d};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic observe();
        if (out_valid && !out_ready) check("R9 in_ready under stall", 36'(in_ready), 36'd0);
        if (out_valid && out_ready) begin
            if (head == tail) check("R9 unexpected output", 36'd1, 36'd0);
            else begin
                check(tag_q[head % 64], {out_be, out_data}, exp_q[head % 64]);
                head++;
            end
        end
        if (in_valid && in_ready) begin
            exp_q[tail % 64] = ref_calc(in_x, in_y, in_src, in_dst);
            tag_q[tail % 64] = phase;
            tail++;
        end
    endtask

    task automatic send(input logic [15:0] x, input logic [15:0] y,
                        input logic [31:0] src, input logic [31:0] dst);
        bit done = 0;
        @(negedge clk);
        in_valid = 1; in_x = x; in_y = y; in_src = src; in_dst = dst;
        out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
        #1;
        done = in_ready;
        observe();
        while (!done) begin
            @(negedge clk);
            out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
            #1;
            done = in_ready;
            observe();
        end
        @(negedge clk);
        in_valid = 0;
        out_ready = 1;
        #1;
        observe();
    endtask

    task automatic drain();
        in_valid = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            out_ready = 1;
            #1;
            observe();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        check("R1 out_valid after reset", 36'(out_valid), 36'd0);
        check("R1 in_ready after reset", 36'(in_ready), 36'd1);

        cfg_pat_tile = 64'h0123_4567_89AB_CDEF;
        cfg_pat_fg = 8'hF0; cfg_pat_bg = 8'h0F;
        cfg_src_fg = 8'hA5; cfg_src_bg = 8'h3C;

        phase = "R2 copy source"; cfg_rop = 8'hCC;
        send(16'd0, 16'd0, 32'h1234_5678, 32'hDEAD_BEEF);
        phase = "R2 dest keep"; cfg_rop = 8'hAA;
        send(16'd3, 16'd1, 32'h1234_5678, 32'hDEAD_BEEF);
        phase = "R2 zero"; cfg_rop = 8'h00;
        send(16'd0, 16'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        phase = "R2 ones"; cfg_rop = 8'hFF;
        send(16'd0, 16'd0, 32'h0, 32'h0);
        phase = "R4 pattern copy"; cfg_rop = 8'hF0;
        send(16'd0, 16'd2, 32'h0, 32'h0);
        phase = "R3 x wrap across lanes"; cfg_rop = 8'hF0;
        send(16'd6, 16'd15, 32'h0, 32'h0);
        phase = "R3 pattern xor dest"; cfg_rop = 8'h5A;
        send(16'hFFFE, 16'd7, 32'h0, 32'h8899_AABB);
        phase = "R5 mono expand"; cfg_rop = 8'hCC; cfg_src_mono = 1;
        send(16'd0, 16'd0, 32'h0000_0005, 32'h0);
        phase = "R6 src transparency"; cfg_src_transp = 1;
        send(16'd0, 16'd0, 32'h0000_0009, 32'h0);
        send(16'd0, 16'd0, 32'h0000_0000, 32'h1111_1111);
        phase = "R6 transp ignored in colour mode"; cfg_src_mono = 0;
        send(16'd0, 16'd0, 32'h0101_0100, 32'h0);
        phase = "R7 pat transparency"; cfg_src_transp = 0; cfg_pat_transp = 1; cfg_rop = 8'hCC;
        send(16'd1, 16'd4, 32'hCAFE_F00D, 32'h0);
        cfg_pat_tile = 64'h0; send(16'd0, 16'd0, 32'h1, 32'h2);
        cfg_pat_transp = 0;
        drain();

        phase = "R8 latency";
        out_ready = 0;
        @(negedge clk);
        in_valid = 1; in_src = 32'h7; #1; observe();
        @(negedge clk);
        in_valid = 0; #1;
        check("R8 out_valid next cycle", 36'(out_valid), 36'd1);
        observe();
        drain();

        phase = "R2/R3/R4/R5/R6/R7/R9 random";
        rnd_ready = 1;
        for (int n = 0; n < 400; n++) begin
            cfg_rop = 8'($urandom);
            cfg_src_mono = 1'($urandom); cfg_src_transp = 1'($urandom);
            cfg_pat_transp = 1'($urandom);
            cfg_pat_tile = {$urandom, $urandom};
            cfg_pat_fg = 8'($urandom); cfg_pat_bg = 8'($urandom);
            cfg_src_fg = 8'($urandom); cfg_src_bg = 8'($urandom);
            send(16'($urandom), 16'($urandom), $urandom, $urandom);
        end
        rnd_ready = 0;
        drain();
        check("R9 all results delivered in order", 36'(tail - head), 36'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule